// File: doc/BRIEF.md
# Byte/Half-Word Dual-Bank Memory

This block is a 16-bit memory that software addresses in bytes. Storage is split into two 8-bit banks, a low lane and a high lane, which share one word address. A combinational steering network between the banks and the external buses moves bytes into the right lane on writes and back into the low lane on reads. A lane-enable circuit decides which bank may write in each cycle.

A size control picks a single-byte transfer or a 16-bit transfer. Address bit 0 picks the lane only for byte transfers. A 16-bit transfer at an odd address is not split into two cycles. It uses the aligned pair that starts at the even address below and raises a one-cycle misalignment flag. The banks are synchronous: a write lands on the clock edge, and read data appears one cycle after the request. Between reads the read bus holds its last value.

Top module: `dual_bank_mem`

## Requirements
- R1: While reset is held, and in the first cycle after it, `rd_data` is 0 and `misaligned` is 0.
- R2: A 16-bit write (`sel`=1, `wr_en`=1, `byte_mode`=0) stores `wr_data[7:0]` at even byte address `addr & ~1` (low bank) and `wr_data[15:8]` at `(addr & ~1) + 1` (high bank). The value of `addr[0]` does not matter.
- R3: A 16-bit read (`sel`=1, `wr_en`=0, `byte_mode`=0) puts {byte at odd address, byte at even address} of the aligned pair on `rd_data` one cycle later. For example, address 15 returns the pair at 14, and address 16 returns the pair at 16.
- R4: A byte write (`byte_mode`=1) stores `wr_data[7:0]` only in the bank chosen by `addr[0]` (0 = low bank, 1 = high bank). The other byte of the pair is unchanged, and `wr_data[15:8]` is ignored.
- R5: A byte read returns the addressed byte on `rd_data[7:0]` one cycle later, with `rd_data[15:8]` equal to 0.
- R6: A read in the cycle right after a write to the same location returns the newly written data. A write cycle leaves `rd_data` unchanged in the next cycle.
- R7: With `sel`=0, no bank is written, whatever the other inputs are, and `rd_data` keeps its value in the next cycle.
- R8: `misaligned` is 1 in the cycle after a selected 16-bit access (read or write) with `addr[0]`=1. In every other case it is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Access request for this cycle |
| wr_en | input | 1 | 1 = write, 0 = read |
| byte_mode | input | 1 | 1 = byte transfer, 0 = 16-bit transfer |
| addr | input | ADDR_W | Byte address |
| wr_data | input | 16 | Write data bus |
| rd_data | output | 16 | Read data bus, valid one cycle after a read |
| misaligned | output | 1 | One-cycle flag for a 16-bit access at an odd address |

## Verification
The hardest case to reach from the ports is a byte write followed by a 16-bit read of the same pair, where the untouched neighbouring byte must still be intact. The same holds for an odd-address 16-bit write whose bytes are then read back one at a time. The stimulus first fills the whole memory with a known value. It then runs directed sequences at addresses 14 to 21 and a long random phase confined to 64 bytes, so that byte and 16-bit accesses collide often. A behavioural byte-array model predicts `rd_data` and `misaligned` on every cycle.

// File: rtl/dbm_pkg.sv
package dbm_pkg;

  localparam int LANE_W  = 8;
  localparam int LANES   = 2;
  localparam int BUS_W   = LANE_W * LANES;

  typedef logic [LANE_W-1:0] lane_t;
  typedef logic [BUS_W-1:0]  bus_t;

  // lane that a byte address falls in
  function automatic logic lane_of(input logic a0);
    return a0;
  endfunction

  // write-enable per lane for a write request
  function automatic logic [LANES-1:0] lane_we(input logic is_byte,
                                               input logic a0);
    logic [LANES-1:0] v;
    if (is_byte) v = (a0 == 1'b1) ? 2'b10 : 2'b01;
    else         v = 2'b11;
    return v;
  endfunction

  // data offered to a lane on a write
  function automatic lane_t lane_wdata(input bus_t wd, input logic is_byte,
                                       input int lane);
    lane_t r;
    if (is_byte) r = wd[LANE_W-1:0];
    else         r = wd[lane*LANE_W +: LANE_W];
    return r;
  endfunction

  // read-side steering of the two bank outputs onto the bus
  function automatic bus_t lane_rdata(input lane_t lo, input lane_t hi,
                                      input logic is_byte, input logic a0);
    bus_t r;
    if (is_byte) r = {{LANE_W{1'b0}}, (a0 ? hi : lo)};
    else         r = {hi, lo};
    return r;
  endfunction

endpackage

// File: rtl/dbm_bank.sv
module dbm_bank #(
  parameter int WA_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic                     we,
  input  logic [WA_W-1:0]          waddr,
  input  dbm_pkg::lane_t           d,
  output dbm_pkg::lane_t           q
);
  localparam int DEPTH = 1 << WA_W;

  dbm_pkg::lane_t store [DEPTH];

  always_ff @(posedge clk) begin
    if (en && we) store[waddr] <= d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          q <= '0;
    else if (en && !we)  q <= store[waddr];
  end

endmodule

// File: rtl/dbm_lane_sel.sv
module dbm_lane_sel (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic       wr_en,
  input  logic       byte_mode,
  input  logic       a0,
  output logic [1:0] bank_en,
  output logic [1:0] bank_we
);
  import dbm_pkg::*;

  logic [1:0] we_mask;

  always_comb begin
    we_mask = lane_we(byte_mode, a0);
    bank_en = sel ? 2'b11 : 2'b00;
    bank_we = (sel && wr_en) ? we_mask : 2'b00;
  end

  // R7: an unselected cycle enables no bank write
  a_r7_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> (bank_we == 2'b00));

  // R4: a byte write touches exactly one bank, the one named by a0
  a_r4_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_en && byte_mode) |-> ($countones(bank_we) == 1 && bank_we[a0]));

  // R2: a 16-bit write enables both banks
  a_r2_both_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_en && !byte_mode) |-> (bank_we == 2'b11));

endmodule

// File: rtl/dbm_align.sv
module dbm_align (
  input  logic                        wr_byte,
  input  dbm_pkg::bus_t               wr_bus,
  output dbm_pkg::lane_t [1:0]        lane_d,
  input  logic                        rd_byte,
  input  logic                        rd_a0,
  input  dbm_pkg::lane_t [1:0]        lane_q,
  output dbm_pkg::bus_t               rd_bus
);
  import dbm_pkg::*;

  for (genvar g = 0; g < LANES; g++) begin : g_wlane
    assign lane_d[g] = lane_wdata(wr_bus, wr_byte, g);
  end

  assign rd_bus = lane_rdata(lane_q[0], lane_q[1], rd_byte, rd_a0);

endmodule

// File: rtl/dual_bank_mem.sv
module dual_bank_mem #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr_en,
  input  logic              byte_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wr_data,
  output logic [15:0]       rd_data,
  output logic              misaligned
);
  import dbm_pkg::*;

  localparam int WA_W = ADDR_W - 1;

  logic [WA_W-1:0]     word_addr;
  logic                a0;
  logic [1:0]          bank_en;
  logic [1:0]          bank_we;
  lane_t [1:0]         lane_d;
  lane_t [1:0]         lane_q;
  logic                rd_req;
  logic                hw_odd_evt;
  logic                rd_byte_q;
  logic                rd_a0_q;
  logic                mis_q;

  assign word_addr  = addr[ADDR_W-1:1];
  assign a0         = addr[0];
  assign rd_req     = sel && !wr_en;
  assign hw_odd_evt = sel && !byte_mode && a0;

  dbm_lane_sel u_lane_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .wr_en     (wr_en),
    .byte_mode (byte_mode),
    .a0        (a0),
    .bank_en   (bank_en),
    .bank_we   (bank_we)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_bank
    dbm_bank #(.WA_W(WA_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (bank_en[g] && (bank_we[g] || rd_req)),
      .we    (bank_we[g]),
      .waddr (word_addr),
      .d     (lane_d[g]),
      .q     (lane_q[g])
    );
  end

  // lane controls for the read in flight; held between reads
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_byte_q <= 1'b0;
      rd_a0_q   <= 1'b0;
      mis_q     <= 1'b0;
    end else begin
      mis_q <= hw_odd_evt;
      if (rd_req) begin
        rd_byte_q <= byte_mode;
        rd_a0_q   <= a0;
      end
    end
  end

  dbm_align u_align (
    .wr_byte (byte_mode),
    .wr_bus  (wr_data),
    .lane_d  (lane_d),
    .rd_byte (rd_byte_q),
    .rd_a0   (rd_a0_q),
    .lane_q  (lane_q),
    .rd_bus  (rd_data)
  );

  assign misaligned = mis_q;

  // R5: a byte read clears the upper lane of the returned value
  a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !wr_en && byte_mode) |=> (rd_data[15:8] == 8'h00));

  // R7: unselected cycle holds the read bus
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable(rd_data));

  // R6: write cycle holds the read bus
  a_r6_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_en) |=> $stable(rd_data));

  // R8: flag follows an odd 16-bit access, and only that
  a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !byte_mode && addr[0]) |=> misaligned);
  a_r8_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && !byte_mode && addr[0]) |=> !misaligned);

endmodule

// File: tb/dual_bank_mem_tb.sv
module dual_bank_mem_tb;
  localparam int AW = 10;
  localparam int NB = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel = 1'b0, wr_en = 1'b0, byte_mode = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0]   wr_data = '0;
  logic [15:0]   rd_data;
  logic          misaligned;

  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  dual_bank_mem #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en),
    .byte_mode(byte_mode), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .misaligned(misaligned)
  );

  // behavioural reference: flat byte array
  logic [7:0]  m [NB];
  logic [15:0] exp_rd;
  logic        exp_mis;
  string       exp_tag;

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_rd  <= 16'h0;
      exp_mis <= 1'b0;
      exp_tag <= "R1";
    end else begin
      int ev;
      ev = int'(addr) & ~1;
      exp_mis <= sel && !byte_mode && addr[0];
      if (!sel)          exp_tag <= "R7";
      else if (wr_en)    exp_tag <= "R6";
      else if (byte_mode) exp_tag <= "R5";
      else               exp_tag <= "R3";
      if (sel && !wr_en) begin
        if (byte_mode) exp_rd <= {8'h00, m[int'(addr)]};
        else           exp_rd <= {m[ev+1], m[ev]};
      end
      if (sel && wr_en) begin
        if (byte_mode) m[int'(addr)] <= wr_data[7:0];       // R4
        else begin m[ev] <= wr_data[7:0]; m[ev+1] <= wr_data[15:8]; end  // R2
      end
    end
  end

  task automatic check(input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: check outputs from the previous edge, then drive the next op
  task automatic cyc(input logic s, input logic w, input logic b,
                     input int a, input logic [15:0] d);
    @(negedge clk);
    check(exp_tag, rd_data, exp_rd);
    check("R8", {15'h0, misaligned}, {15'h0, exp_mis});
    sel = s; wr_en = w; byte_mode = b; addr = AW'(a); wr_data = d;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check("R1", rd_data, 16'h0);
    check("R1", {15'h0, misaligned}, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1", rd_data, 16'h0);
    // R2: fill memory with 16-bit writes
    for (int i = 0; i < NB; i += 2) cyc(1, 1, 0, i, 16'h5A00 | 16'(i[7:0]));
    // R2/R8: odd 16-bit write lands on aligned pair 14/15
    cyc(1, 1, 0, 15, 16'hBEEF);
    cyc(1, 0, 1, 14, 16'h0);   // R5: expect EF
    cyc(1, 0, 1, 15, 16'h0);   // R5: expect BE
    cyc(1, 0, 0, 15, 16'h0);   // R3: odd read -> pair at 14
    cyc(1, 0, 0, 14, 16'h0);
    cyc(0, 0, 0, 0, 16'h0);
    check("R3", rd_data, 16'hBEEF);
    // R4: byte writes leave neighbour intact, upper write bits ignored
    cyc(1, 1, 1, 20, 16'h12AB);
    cyc(1, 1, 1, 21, 16'h34CD);
    cyc(1, 0, 0, 20, 16'h0);   // R6: read right after write
    cyc(1, 0, 0, 16, 16'h0);   // R3: even read
    cyc(0, 0, 0, 0, 16'h0);
    check("R4", rd_data, 16'h5A10);
    // R7: unselected cycles with write controls active must not write
    cyc(0, 1, 0, 20, 16'hFFFF);
    cyc(0, 1, 1, 21, 16'hFFFF);
    cyc(1, 0, 0, 20, 16'h0);
    cyc(0, 0, 0, 0, 16'h0);
    check("R7", rd_data, 16'hCDAB);
    // random phase on a small window to force collisions
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[0] | r[1], r[2], r[3], int'(r[9:4]), r[31:16]);
    end
    cyc(0, 0, 0, 0, 16'h0);
    cyc(0, 0, 0, 0, 16'h0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule